// File: doc/BRIEF.md
# Masked Line-Change Timestamp Recorder

This block watches a wide, parameterised bundle of asynchronous input lines. Each line is brought into the clock domain and compared with its previous level. When a line whose enable bit is set changes level, in either direction, the block takes the value of an external free-running counter and queues a record. The record holds the counter value, the line number and the new level. Records enter an on-chip FIFO that software drains through a small word-addressed register port.

Enable bits are kept in 32-bit slices, so one register word covers 32 lines. The slice count is a parameter; typical builds use 3, 11 or 17 slices (96, 352 or 544 lines). Several enabled lines can change in the same cycle. Each such change is held pending on its own line and is written to the FIFO one per cycle, lowest line number first.

A level-sensitive interrupt is high while the FIFO holds at least a programmable number of records. If the FIFO is full, a new record is dropped and a sticky overflow bit is raised. Software clears that bit by writing 1 to it.

Top module: `ets_top`

## Requirements
- R1: Each line goes through a two-flop synchroniser and then an edge detector. A rising change and a falling change on an enabled line each produce one record. The record's level bit (pop word bit 16) holds the line's new level.
- R2: A record carries three fields. The first is the counter value sampled when the change is detected, readable as the low word at offset S+2 and the high word at offset S+3 (S = slice count). The second is the line number, in pop word bits 15:0. The third is the new level.
- R3: Enable slice k is read and written at word offset k, and bit b of that word enables line 32k+b. A change on a line whose enable bit is 0 produces no record. Enables reset to 0.
- R4: When several enabled lines change in the same cycle, their records enter the FIFO in ascending line-number order, one per cycle.
- R5: A record that finds the FIFO full is dropped, and overflow status bit 0 (offset S+1) is set. The bit stays set until a write to offset S+1 with bit 0 equal to 1. A write with bit 0 equal to 0 leaves it set.
- R6: A read of the pop word (offset S+4) returns bit 31 = 1 with the head record and removes that record. With the FIFO empty, the pop word and both counter words read as zero, and the occupancy (status bits starting at 16) stays 0.
- R7: The interrupt output is high exactly when the occupancy of the previous cycle was at least the threshold. It falls once records are popped below the threshold.
- R8: The threshold lives at offset S. It resets to 1. A written value is clamped to the range 1 to FIFO depth, so 0 reads back as 1 and values above the depth read back as the depth.
- R9: After reset the FIFO is empty, the interrupt is low, the overflow bit is clear and every enable bit is 0.
- R10: Records leave the FIFO in the order they entered it, including across separate bursts and when the FIFO runs completely full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| lines_i | input | SLICES*32 | Monitored asynchronous lines |
| counter_i | input | TS_W | Free-running system counter value |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Occupancy-threshold interrupt, level-sensitive |

## Verification
Errors in the per-line pending bits or in the priority encoder appear as records that are missing, duplicated or out of order. They show up at the pop word as soon as the burst is drained, about one line-count of cycles after the edges. A FIFO pointer or head-register error returns stale or shifted counter values on the very next pop. An occupancy error is visible in the status word and moves the interrupt one cycle later. The overflow path is driven past full with bursts on every line, and it is checked through the status bit and through which records survive.

// File: rtl/ets_pkg.sv
package ets_pkg;
  localparam int unsigned SLICE_W   = 32;
  localparam int unsigned WORD_W    = 32;
  // register offsets that follow the last enable slice
  localparam int unsigned REG_THR   = 0;
  localparam int unsigned REG_STAT  = 1;
  localparam int unsigned REG_TS_LO = 2;
  localparam int unsigned REG_TS_HI = 3;
  localparam int unsigned REG_POP   = 4;
  localparam int unsigned REG_EXTRA = 5;
  // field positions
  localparam int unsigned POP_VALID_BIT = 31;
  localparam int unsigned POP_LEVEL_BIT = 16;
  localparam int unsigned STAT_OCC_LSB  = 16;

  function automatic int unsigned clamp_thr(input logic [31:0] v, input int unsigned depth);
    if (v == 32'd0) return 1;
    if (v > depth) return depth;
    return int'(v);
  endfunction
endpackage

// File: rtl/ets_sync_edge.sv
module ets_sync_edge #(
  parameter int unsigned N = 96
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [N-1:0] lines_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] change_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= lines_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level_o  = sync_q;
  assign change_o = sync_q ^ prev_q;
endmodule

// File: rtl/ets_pending_arb.sv
module ets_pending_arb #(
  parameter int unsigned N     = 96,
  parameter int unsigned TS_W  = 64,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [N-1:0]     evt_i,
  input  logic [N-1:0]     level_i,
  input  logic [TS_W-1:0]  stamp_i,
  output logic             req_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [TS_W-1:0]  ts_o,
  output logic             lvl_o,
  output logic [N-1:0]     grant_o,
  output logic [N-1:0]     pend_o
);
  logic [N-1:0]    pend_q;
  logic [N-1:0]    lvl_q;
  logic [TS_W-1:0] ts_q [N];

  // lowest pending line wins
  always_comb begin
    req_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        req_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  assign grant_o = req_o ? (N'(1) << idx_o) : '0;
  assign ts_o    = ts_q[idx_o];
  assign lvl_o   = lvl_q[idx_o];
  assign pend_o  = pend_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) pend_q <= '0;
    else       pend_q <= (pend_q & ~grant_o) | evt_i;
  end

  // a newer change on a still-pending line replaces its stamp and level
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < N; i++) begin
      if (evt_i[i]) begin
        ts_q[i]  <= stamp_i;
        lvl_q[i] <= level_i[i];
      end
    end
  end
endmodule

// File: rtl/ets_fifo.sv
module ets_fifo #(
  parameter int unsigned W     = 72,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q, rp_n;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     head_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rp_n    = do_pop ? rp_q + PTR_W'(1) : rp_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= din_i;
  end

  // head register tracks mem[rp]; bypass when the write lands on it
  always_ff @(posedge clk_i) begin
    if (do_push && (wp_q == rp_n)) head_q <= din_i;
    else                           head_q <= mem[rp_n];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + PTR_W'(1);
      rp_q <= rp_n;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = head_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/ets_top.sv
module ets_top #(
  parameter int unsigned SLICES = 3,
  parameter int unsigned TS_W   = 64,
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned LINES  = SLICES * ets_pkg::SLICE_W,
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned REC_W  = TS_W + IDX_W + 1,
  localparam int unsigned ADDR_W = $clog2(SLICES + ets_pkg::REG_EXTRA)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [LINES-1:0]  lines_i,
  input  logic [TS_W-1:0]   counter_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  import ets_pkg::*;

  localparam logic [ADDR_W-1:0] A_THR   = ADDR_W'(SLICES + REG_THR);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(SLICES + REG_STAT);
  localparam logic [ADDR_W-1:0] A_TS_LO = ADDR_W'(SLICES + REG_TS_LO);
  localparam logic [ADDR_W-1:0] A_TS_HI = ADDR_W'(SLICES + REG_TS_HI);
  localparam logic [ADDR_W-1:0] A_POP   = ADDR_W'(SLICES + REG_POP);

  logic [LINES-1:0] lvl, chg, evt, grant, pend;
  logic [LINES-1:0] en_q;
  logic             arb_req, arb_lvl;
  logic [IDX_W-1:0] arb_idx;
  logic [TS_W-1:0]  arb_ts;
  logic [REC_W-1:0] head;
  logic [CNT_W-1:0] fifo_cnt;
  logic             fifo_empty, fifo_full;
  logic             push, pop_req, pop;
  logic [CNT_W-1:0] thr_q;
  logic             ovf_q, ovf_clr, irq_q;
  logic [31:0]      rd_val, rdata_q;
  logic [TS_W-1:0]  head_ts;
  logic [IDX_W-1:0] head_idx;
  logic             head_lvl;

  ets_sync_edge #(.N(LINES)) u_sync (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .lines_i  (lines_i),
    .level_o  (lvl),
    .change_o (chg)
  );

  assign evt = chg & en_q;

  ets_pending_arb #(.N(LINES), .TS_W(TS_W), .IDX_W(IDX_W)) u_arb (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .evt_i   (evt),
    .level_i (lvl),
    .stamp_i (counter_i),
    .req_o   (arb_req),
    .idx_o   (arb_idx),
    .ts_o    (arb_ts),
    .lvl_o   (arb_lvl),
    .grant_o (grant),
    .pend_o  (pend)
  );

  assign push    = arb_req && !fifo_full;
  assign pop_req = reg_rd_i && (reg_addr_i == A_POP);
  assign pop     = pop_req && !fifo_empty;

  ets_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .push_i  (push),
    .din_i   ({arb_ts, arb_idx, arb_lvl}),
    .pop_i   (pop),
    .head_o  (head),
    .count_o (fifo_cnt),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  assign head_ts  = head[REC_W-1 -: TS_W];
  assign head_idx = head[IDX_W:1];
  assign head_lvl = head[0];

  // enable bitmap, one word per slice
  genvar k;
  generate
    for (k = 0; k < SLICES; k++) begin : g_slice
      always_ff @(posedge clk_i) begin
        if (rst_i) en_q[k*SLICE_W +: SLICE_W] <= '0;
        else if (reg_wr_i && (reg_addr_i == ADDR_W'(k)))
          en_q[k*SLICE_W +: SLICE_W] <= reg_wdata_i;
      end
    end
  endgenerate

  assign ovf_clr = reg_wr_i && (reg_addr_i == A_STAT) && reg_wdata_i[0];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      thr_q <= CNT_W'(1);
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (reg_wr_i && (reg_addr_i == A_THR))
        thr_q <= CNT_W'(clamp_thr(reg_wdata_i, DEPTH));
      // a drop in the same cycle as a clear wins
      if (arb_req && fifo_full) ovf_q <= 1'b1;
      else if (ovf_clr)         ovf_q <= 1'b0;
      irq_q <= (fifo_cnt >= thr_q);
    end
  end

  always_comb begin
    rd_val = '0;
    for (int s = 0; s < SLICES; s++) begin
      if (reg_addr_i == ADDR_W'(s)) rd_val = en_q[s*SLICE_W +: SLICE_W];
    end
    if (reg_addr_i == A_THR) begin
      rd_val[CNT_W-1:0] = thr_q;
    end else if (reg_addr_i == A_STAT) begin
      rd_val[0] = ovf_q;
      rd_val[STAT_OCC_LSB +: CNT_W] = fifo_cnt;
    end else if (reg_addr_i == A_TS_LO) begin
      if (!fifo_empty) rd_val = head_ts[31:0];
    end else if (reg_addr_i == A_TS_HI) begin
      if (!fifo_empty) rd_val = 32'(head_ts >> 32);
    end else if (reg_addr_i == A_POP) begin
      if (!fifo_empty) begin
        rd_val[15:0]          = 16'(head_idx);
        rd_val[POP_LEVEL_BIT] = head_lvl;
        rd_val[POP_VALID_BIT] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)         rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_val;
    else               rdata_q <= '0;
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/ets_checker.sv
module ets_checker #(
  parameter int unsigned LINES = 96,
  parameter int unsigned DEPTH = 256,
  parameter int unsigned CNT_W = 9
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             irq_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] thr_i,
  input logic [LINES-1:0] grant_i,
  input logic [LINES-1:0] pend_i,
  input logic             req_i,
  input logic             full_i,
  input logic             ovf_i,
  input logic             clr_i,
  input logic             pop_req_i,
  input logic             push_i
);
  p_irq_level_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_i == $past(cnt_i >= thr_i));

  p_grant_onehot_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(grant_i));

  p_grant_pending_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (grant_i & ~pend_i) == '0);

  p_full_drop_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_i && full_i) |=> ovf_i);

  p_ovf_sticky_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (ovf_i && !clr_i) |=> ovf_i);

  p_occ_bound_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_i <= CNT_W'(DEPTH));

  p_empty_pop_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (pop_req_i && cnt_i == '0 && !push_i) |=> cnt_i == '0);

  p_thr_range_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (thr_i >= CNT_W'(1)) && (thr_i <= CNT_W'(DEPTH)));
endmodule

bind ets_top ets_checker #(.LINES(LINES), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .irq_i     (irq_o),
  .cnt_i     (fifo_cnt),
  .thr_i     (thr_q),
  .grant_i   (grant),
  .pend_i    (pend),
  .req_i     (arb_req),
  .full_i    (fifo_full),
  .ovf_i     (ovf_q),
  .clr_i     (ovf_clr),
  .pop_req_i (pop_req),
  .push_i    (push)
);

// File: tb/tb_ets_top.sv
module tb_ets_top;
  localparam int unsigned SLICES = 3;
  localparam int unsigned TS_W   = 64;
  localparam int unsigned DEPTH  = 256;
  localparam int unsigned LINES  = SLICES * 32;
  localparam int unsigned IDX_W  = $clog2(LINES);
  localparam int unsigned ADDR_W = $clog2(SLICES + 5);
  localparam int A_THR = SLICES, A_STAT = SLICES + 1, A_LO = SLICES + 2,
                 A_HI = SLICES + 3, A_POP = SLICES + 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [LINES-1:0]  lines = '0;
  logic [TS_W-1:0]   counter = '0;
  logic              wr = 1'b0, rd = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [LINES-1:0] en_m = '0;
  logic [TS_W+IDX_W:0] exp_q[$];

  always #2 clk = ~clk;

  ets_top #(.SLICES(SLICES), .TS_W(TS_W), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_i(rst), .lines_i(lines), .counter_i(counter),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(int a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_rd(int a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = ADDR_W'(a);
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  function automatic logic [31:0] occ_of(logic [31:0] s);
    return (s >> 16) & 32'h1FF;
  endfunction

  // toggle the masked lines with a fixed counter, update the model
  task automatic burst(logic [LINES-1:0] mask, logic [TS_W-1:0] cval);
    @(negedge clk);
    counter = cval;
    @(negedge clk);
    lines = lines ^ mask;
    for (int i = 0; i < LINES; i++) begin
      if (mask[i] && en_m[i] && exp_q.size() < DEPTH)
        exp_q.push_back({cval, IDX_W'(i), lines[i]});
    end
    repeat (LINES + 10) @(negedge clk);
  endtask

  task automatic pop_one(string tag);
    logic [31:0] lo, hi, pw;
    logic [TS_W+IDX_W:0] e;
    e = exp_q.pop_front();
    reg_rd(A_LO, lo);
    reg_rd(A_HI, hi);
    reg_rd(A_POP, pw);
    chk({tag, " stamp"}, {hi, lo}, e[TS_W+IDX_W -: TS_W]);
    chk({tag, " line"}, 64'(pw[15:0]), 64'(e[IDX_W:1]));
    chk({tag, " level"}, 64'(pw[16]), 64'(e[0]));
    chk({tag, " valid"}, 64'(pw[31]), 64'd1);
  endtask

  task automatic drain(string tag);
    logic [31:0] s;
    reg_rd(A_STAT, s);
    chk({tag, " occupancy"}, 64'(occ_of(s)), 64'(exp_q.size()));
    while (exp_q.size() > 0) pop_one(tag);
  endtask

  task automatic set_en(logic [LINES-1:0] e);
    for (int s = 0; s < SLICES; s++) reg_wr(s, e[s*32 +: 32]);
    en_m = e;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [LINES-1:0] m;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R9 reset state
    chk("R9 irq low", 64'(irq), 64'd0);
    reg_rd(A_STAT, d); chk("R9 status", 64'(d), 64'd0);
    reg_rd(1, d);      chk("R9 enable slice", 64'(d), 64'd0);
    reg_rd(A_THR, d);  chk("R8 threshold reset", 64'(d), 64'd1);

    // R3 disabled lines are ignored
    burst({LINES{1'b1}}, 64'h55);
    reg_rd(A_STAT, d); chk("R3 no record when disabled", 64'(occ_of(d)), 64'd0);
    set_en({LINES{1'b1}} ^ (LINES'(1) << 40));
    reg_rd(1, d); chk("R3 slice1 readback", 64'(d), 64'hFFFFFEFF);
    burst(LINES'(1) << 40, 64'h66);
    reg_rd(A_STAT, d); chk("R3 masked line 40", 64'(occ_of(d)), 64'd0);

    // R1 R2 rise then fall on line 5
    set_en(LINES'(1) << 5 | LINES'(1) << 2 | LINES'(1) << 70);
    burst(LINES'(1) << 5, 64'h1122_3344_5566_7788);
    drain("R1 R2 rise");
    burst(LINES'(1) << 5, 64'hDEAD_BEEF_0BAD_F00D);
    drain("R1 fall");

    // R4 simultaneous changes leave in ascending order
    burst(LINES'(1) << 70 | LINES'(1) << 5 | LINES'(1) << 2, 64'hA5A5_0000_0000_0001);
    drain("R4 ascending");

    // R6 empty reads
    reg_rd(A_POP, d); chk("R6 empty pop word", 64'(d), 64'd0);
    reg_rd(A_LO, d);  chk("R6 empty stamp word", 64'(d), 64'd0);
    reg_rd(A_STAT, d); chk("R6 occupancy after empty pop", 64'(occ_of(d)), 64'd0);

    // R8 threshold clamp
    reg_wr(A_THR, 0);    reg_rd(A_THR, d); chk("R8 clamp low", 64'(d), 64'd1);
    reg_wr(A_THR, 1000); reg_rd(A_THR, d); chk("R8 clamp high", 64'(d), 64'(DEPTH));
    reg_wr(A_THR, 3);    reg_rd(A_THR, d); chk("R8 write 3", 64'(d), 64'd3);

    // R7 interrupt against threshold 3
    set_en('1);
    burst(LINES'(1) << 1 | LINES'(1) << 2, 64'h10);
    chk("R7 irq below threshold", 64'(irq), 64'd0);
    burst(LINES'(1) << 3, 64'h20);
    chk("R7 irq at threshold", 64'(irq), 64'd1);
    pop_one("R7 pop");
    repeat (2) @(negedge clk);
    chk("R7 irq after pop", 64'(irq), 64'd0);
    drain("R7 drain");
    reg_wr(A_THR, 1);

    // R5 R10 overflow with full bursts
    burst('1, 64'h1000);
    burst('1, 64'h2000);
    burst('1, 64'h3000);
    reg_rd(A_STAT, d);
    chk("R5 overflow bit", 64'(d[0]), 64'd1);
    chk("R5 occupancy full", 64'(occ_of(d)), 64'(DEPTH));
    chk("R7 irq with records", 64'(irq), 64'd1);
    reg_wr(A_STAT, 0);
    reg_rd(A_STAT, d); chk("R5 write 0 keeps flag", 64'(d[0]), 64'd1);
    drain("R10 full order");
    repeat (2) @(negedge clk);
    chk("R7 irq when empty", 64'(irq), 64'd0);
    reg_wr(A_STAT, 1);
    reg_rd(A_STAT, d); chk("R5 write 1 clears flag", 64'(d[0]), 64'd0);

    // random bursts with random enables
    for (int n = 0; n < 40; n++) begin
      set_en({$urandom, $urandom, $urandom});
      m = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom,
           $urandom & $urandom & $urandom};
      burst(m, {$urandom, $urandom});
      if (n % 3 == 2 || n == 39) drain("R10 R2 random");
    end
    reg_rd(A_STAT, d); chk("R5 no overflow in random", 64'(d[0]), 64'd0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule